// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual page number into its page table entry when a translation cache misses. It walks a two-level radix tree held in memory. The upper ten bits of the 20-bit page number select a word in the top-level table. The top-level table is located by a root pointer supplied by a privileged register. That word either points to a second-level table or marks the region as unmapped. The lower ten bits then select the leaf entry inside the second-level table. Pages are 4 KB, so the 12-bit page offset never enters the walk.

Memory is reached through a single-word read port. A request is held until the memory accepts it, and the data returns on a separate response strobe. Only one walk is in flight at a time. While it runs, `busy` stays high so that the requesting pipeline can stall. The walk ends with a one-cycle completion pulse carrying either the leaf entry or a fault flag.

Every table word uses bit 0 as its valid flag. A top-level word with bit 0 clear (including an all-zero null pointer) ends the walk at once with a fault, and no second read is made. A leaf with bit 0 clear also faults.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, `busy`, `mem_req_valid` and `walk_done` are low until a request is accepted.
- R2: A request (`req_valid` high) is accepted only when `busy` is low. A request presented while `busy` is high is dropped: it starts no walk and causes no memory read, and the walk in progress reads the same addresses it would have read without it.
- R3: `busy` is high from the cycle after a request is accepted up to and including the cycle in which `walk_done` is high. It is low in the cycle after that.
- R4: The first read of a walk goes to `root_ptr + 4*vpn[19:10]`, using the root value present when the request was accepted.
- R5: If the top-level word has bit 0 set, the second read goes to `{word[31:12], 12'h000} + 4*vpn[9:0]`.
- R6: If the top-level word has bit 0 clear, the walk ends with `walk_fault` = 1 and `walk_pte` = 0, after exactly one memory read.
- R7: If the leaf word has bit 0 set, the walk ends with `walk_fault` = 0 and `walk_pte` equal to the whole 32-bit leaf word. That word holds the physical page number in bits [31:12] and permission flags in the low bits.
- R8: If the leaf word has bit 0 clear, the walk ends with `walk_fault` = 1 and `walk_pte` = 0, after exactly two memory reads.
- R9: `walk_done` is high for exactly one cycle per accepted walk. `walk_fault` and `walk_pte` are valid in that cycle.
- R10: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until a cycle in which `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| root_ptr | input | 32 | Byte address of the top-level table, from the privileged root register |
| req_valid | input | 1 | Miss request strobe |
| req_vpn | input | 20 | Virtual page number to resolve |
| busy | output | 1 | Walk in progress; the requester stalls |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request this cycle |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 32 | Read data word |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk found no valid mapping (valid with `walk_done`) |
| walk_pte | output | 32 | Leaf entry, zero on fault (valid with `walk_done`) |

## Verification
On every cycle the assertions check the memory handshake discipline (R10), the single-cycle completion pulse and its overlap with `busy` (R9, R3), and that no read is issued while idle (R2). They also check the result produced after each kind of response word (R6, R7). The bench scenarios cover what needs a whole walk to see. These are the exact addresses formed from the root and from the top-level pointer (R4, R5, including the all-ones index wrap), the count of reads on each fault path (R6, R8), and that a request arriving mid-walk leaves the address trace untouched (R2). They run under stretched memory latency and a throttled request handshake.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_IDX_W      = 10;
  localparam int unsigned DEF_PAGE_SHIFT = 12;
  // table words are 4 bytes wide
  localparam int unsigned ENTRY_SHIFT    = 2;
  localparam int unsigned LEVELS         = 2;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_TOP_REQ = 3'd1,
    WS_TOP_WT  = 3'd2,
    WS_LF_REQ  = 3'd3,
    WS_LF_WT   = 3'd4,
    WS_RESULT  = 3'd5
  } walk_state_e;

endpackage

// File: rtl/pt_walk_addr.sv
// Forms the byte address of the table word for the current level.
module pt_walk_addr
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
  input  logic                       leaf_level,
  input  logic [LEVELS*IDX_W-1:0]    vpn,
  input  logic [ADDR_W-1:0]          root,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] leaf_base,
  output logic [ADDR_W-1:0]          addr
);

  localparam int unsigned PAD_W = ADDR_W - IDX_W - ENTRY_SHIFT;

  logic [IDX_W-1:0] lvl_idx [LEVELS];

  // level 0 takes the most significant slice of the page number
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign lvl_idx[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] byte_off;

  always_comb begin
    sel_idx  = leaf_level ? lvl_idx[1] : lvl_idx[0];
    tbl_base = leaf_level ? {leaf_base, {PAGE_SHIFT{1'b0}}} : root;
    byte_off = {{PAD_W{1'b0}}, sel_idx, {ENTRY_SHIFT{1'b0}}};
    addr     = tbl_base + byte_off;
  end

endmodule

// File: rtl/pt_walk_fsm.sv
// Walk sequencer: request capture, memory handshake, entry decode, result hold.
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [LEVELS*IDX_W-1:0]      req_vpn,
  input  logic [ADDR_W-1:0]            root_ptr,
  input  logic                         mem_req_ready,
  input  logic                         mem_rsp_valid,
  input  logic [ADDR_W-1:0]            mem_rsp_data,
  output logic                         leaf_level,
  output logic [LEVELS*IDX_W-1:0]      vpn_q,
  output logic [ADDR_W-1:0]            root_q,
  output logic [ADDR_W-PAGE_SHIFT-1:0] base_q,
  output logic                         busy,
  output logic                         mem_req_valid,
  output logic                         walk_done,
  output logic                         walk_fault,
  output logic [ADDR_W-1:0]            walk_pte
);

  localparam int unsigned VPN_W  = LEVELS * IDX_W;
  localparam int unsigned BASE_W = ADDR_W - PAGE_SHIFT;

  walk_state_e st_q, st_d;
  logic        cap_req, cap_base, cap_res;
  logic        fault_q;
  logic [ADDR_W-1:0] pte_q;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cap_req  = 1'b0;
    cap_base = 1'b0;
    cap_res  = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          st_d    = WS_TOP_REQ;
          cap_req = 1'b1;
        end
      end
      WS_TOP_REQ: if (mem_req_ready) st_d = WS_TOP_WT;
      WS_TOP_WT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_data[0]) begin
            st_d     = WS_LF_REQ;
            cap_base = 1'b1;
          end else begin
            st_d    = WS_RESULT;
            cap_res = 1'b1;
          end
        end
      end
      WS_LF_REQ: if (mem_req_ready) st_d = WS_LF_WT;
      WS_LF_WT: begin
        if (mem_rsp_valid) begin
          st_d    = WS_RESULT;
          cap_res = 1'b1;
        end
      end
      WS_RESULT: st_d = WS_IDLE;
      default:   st_d = WS_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      root_q <= '0;
    end else if (cap_req) begin
      vpn_q  <= req_vpn;
      root_q <= root_ptr;
    end
  end

  // second-level table base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (cap_base) base_q <= mem_rsp_data[ADDR_W-1:PAGE_SHIFT];
  end

  // result hold; a fault reports a zero entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      pte_q   <= '0;
    end else if (cap_res) begin
      fault_q <= ~mem_rsp_data[0];
      pte_q   <= mem_rsp_data[0] ? mem_rsp_data : '0;
    end
  end

  assign leaf_level    = (st_q == WS_LF_REQ);
  assign busy          = (st_q != WS_IDLE);
  assign mem_req_valid = (st_q == WS_TOP_REQ) || (st_q == WS_LF_REQ);
  assign walk_done     = (st_q == WS_RESULT);
  assign walk_fault    = fault_q;
  assign walk_pte      = pte_q;

  // a top-level word without its valid flag ends the walk next cycle
  p_null_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_TOP_WT && mem_rsp_valid && !mem_rsp_data[0])
      |=> (walk_done && walk_fault && walk_pte == '0 && !mem_req_valid))
    else $error("p_null_ends_r6");

  // a valid leaf is reported unchanged
  p_leaf_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_LF_WT && mem_rsp_valid && mem_rsp_data[0])
      |=> (walk_done && !walk_fault && walk_pte == $past(mem_rsp_data)))
    else $error("p_leaf_fill_r7");

  // an invalid leaf faults
  p_leaf_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_LF_WT && mem_rsp_valid && !mem_rsp_data[0])
      |=> (walk_done && walk_fault))
    else $error("p_leaf_bad_r8");

  // the captured page number is used unchanged for the second-level slice
  p_vpn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_done) |=> $stable(vpn_q) && $stable(root_q))
    else $error("p_vpn_hold_r2");

  logic unused_width;
  assign unused_width = (VPN_W == 0) || (BASE_W == 0);

endmodule

// File: rtl/pt_walker.sv
// Top level of the two-level page table walker.
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         root_ptr,
  input  logic                      req_valid,
  input  logic [LEVELS*IDX_W-1:0]   req_vpn,
  output logic                      busy,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [ADDR_W-1:0]         mem_rsp_data,
  output logic                      walk_done,
  output logic                      walk_fault,
  output logic [ADDR_W-1:0]         walk_pte
);

  localparam int unsigned VPN_W  = LEVELS * IDX_W;
  localparam int unsigned BASE_W = ADDR_W - PAGE_SHIFT;

  logic              leaf_level;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] root_q;
  logic [BASE_W-1:0] base_q;

  pt_walk_fsm #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vpn       (req_vpn),
    .root_ptr      (root_ptr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .leaf_level    (leaf_level),
    .vpn_q         (vpn_q),
    .root_q        (root_q),
    .base_q        (base_q),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault),
    .walk_pte      (walk_pte)
  );

  pt_walk_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .leaf_level (leaf_level),
    .vpn        (vpn_q),
    .root       (root_q),
    .leaf_base  (base_q),
    .addr       (mem_req_addr)
  );

  // memory request held with a steady address until taken
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("p_req_hold_r10");

  // completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done)
    else $error("p_done_pulse_r9");

  // completion lies inside the busy window, which closes right after it
  p_busy_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> busy ##1 !busy)
    else $error("p_busy_span_r3");

  // nothing is read while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid)
    else $error("p_idle_quiet_r2");

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/100ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_ptr;
  logic        req_valid;
  logic [19:0] req_vpn;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        walk_done;
  logic        walk_fault;
  logic [31:0] walk_pte;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
    .req_valid(req_valid), .req_vpn(req_vpn), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .walk_done(walk_done),
    .walk_fault(walk_fault), .walk_pte(walk_pte)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural memory
  logic [31:0] memw [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return memw.exists(a) ? memw[a] : 32'h0;
  endfunction

  function automatic logic [31:0] top_addr(input logic [31:0] root, input logic [19:0] vpn);
    return root + {20'h0, vpn[19:10], 2'b00};
  endfunction
  function automatic logic [31:0] leaf_addr(input logic [31:0] word, input logic [19:0] vpn);
    return {word[31:12], 12'h000} + {20'h0, vpn[9:0], 2'b00};
  endfunction

  // memory responder: records accepted reads, answers after mem_lat cycles
  logic [31:0] addr_q [$];
  int          mem_lat  = 1;
  bit          throttle = 1'b0;
  int          pend     = 0;
  logic [31:0] pend_a   = '0;
  int          cyc      = 0;

  initial begin
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_a);
        end
      end
      mem_req_ready = throttle ? ((cyc % 3) == 2) : 1'b1;
      #0.5;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        addr_q.push_back(mem_req_addr);
        pend_a = mem_req_addr;
        pend   = mem_lat;
      end
    end
  end

  // per-cycle reference of the busy window
  bit walking = 1'b0;
  bit acc_p   = 1'b0;
  bit done_p  = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #1.0;
      if (!rst_n) begin
        walking = 1'b0; acc_p = 1'b0; done_p = 1'b0;
      end else begin
        if (done_p)     walking = 1'b0;
        else if (acc_p) walking = 1'b1;
        chk(busy === walking, "R3 busy window", {31'h0, busy}, {31'h0, walking});
        if (!walking) begin
          chk(!walk_done, "R9 done outside walk", {31'h0, walk_done}, 32'h0);
          chk(!mem_req_valid, "R2 read while idle", {31'h0, mem_req_valid}, 32'h0);
        end
        acc_p  = req_valid && !walking;
        done_p = walk_done;
      end
    end
  end

  task automatic run_walk(input logic [31:0] root, input logic [19:0] vpn,
                          input int lat, input bit thr, input bit inject, input string tag);
    logic [31:0] a1, a2, e1, e2, exp_pte;
    bit          exp_fault;
    int          exp_n, dones, n;
    bit          seen;
    logic        got_fault;
    logic [31:0] got_pte;
    a1 = top_addr(root, vpn);
    e1 = rd(a1);
    a2 = leaf_addr(e1, vpn);
    e2 = rd(a2);
    if (!e1[0]) begin exp_n = 1; exp_fault = 1'b1; exp_pte = 0; end
    else begin exp_n = 2; exp_fault = !e2[0]; exp_pte = e2[0] ? e2 : 32'h0; end

    @(negedge clk);
    while (busy) @(negedge clk);
    addr_q.delete();
    mem_lat = lat; throttle = thr;
    root_ptr = root; req_vpn = vpn; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    root_ptr = 32'hDEAD_0000;
    if (inject) begin
      @(negedge clk);
      req_vpn = ~vpn; root_ptr = root ^ 32'h0000_8000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    seen = 1'b0; n = 0; dones = 0; got_fault = 1'b0; got_pte = '0;
    while (!seen && n < 400) begin
      #1.5;
      if (walk_done) begin
        seen = 1'b1; dones++; got_fault = walk_fault; got_pte = walk_pte;
      end else begin
        @(negedge clk); n++;
      end
    end
    if (!seen) begin
      chk(1'b0, {"R9 walk never completed ", tag}, 32'h0, 32'h1);
      return;
    end
    @(negedge clk);
    #1.5;
    if (walk_done) dones++;
    chk(dones == 1, {"R9 done width ", tag}, dones, 32'h1);
    chk(!busy, {"R3 busy after done ", tag}, {31'h0, busy}, 32'h0);
    chk(got_fault == exp_fault, {"R6 R8 fault flag ", tag}, {31'h0, got_fault}, {31'h0, exp_fault});
    chk(got_pte == exp_pte, {"R7 entry ", tag}, got_pte, exp_pte);
    chk(addr_q.size() == exp_n, {"R6 R8 read count ", tag}, addr_q.size(), exp_n);
    if (addr_q.size() >= 1)
      chk(addr_q[0] == a1, {"R4 top address ", tag}, addr_q[0], a1);
    if (addr_q.size() >= 2 && exp_n == 2)
      chk(addr_q[1] == a2, {"R5 leaf address ", tag}, addr_q[1], a2);
    if (inject)
      chk(addr_q.size() == exp_n, {"R2 mid-walk request dropped ", tag}, addr_q.size(), exp_n);
  endtask

  localparam logic [31:0] RA = 32'h0010_0000;
  localparam logic [31:0] RB = 32'hFFFF_F000;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; root_ptr = '0;

    // table contents
    memw[top_addr(RA, 20'h12345)] = 32'h0020_3001;
    memw[leaf_addr(32'h0020_3001, 20'h12345)] = 32'hABCD_E00F;
    memw[top_addr(RA, 20'h00800)] = 32'h0030_5000;
    memw[top_addr(RA, 20'h00C07)] = 32'h0030_6001;
    memw[leaf_addr(32'h0030_6001, 20'h00C07)] = 32'h1234_500E;
    memw[top_addr(RB, 20'hFFFFF)] = 32'h7FFF_F001;
    memw[leaf_addr(32'h7FFF_F001, 20'hFFFFF)] = 32'h00AB_C007;
    memw[top_addr(RA, 20'h00000)] = 32'h0040_1001;
    memw[leaf_addr(32'h0040_1001, 20'h00000)] = 32'h5555_5003;

    repeat (3) @(negedge clk);
    #1.5;
    chk(!busy, "R1 busy in reset", {31'h0, busy}, 32'h0);
    chk(!mem_req_valid, "R1 read in reset", {31'h0, mem_req_valid}, 32'h0);
    chk(!walk_done, "R1 done in reset", {31'h0, walk_done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1.5;
    chk(!busy && !mem_req_valid && !walk_done, "R1 idle after reset",
        {29'h0, busy, mem_req_valid, walk_done}, 32'h0);

    run_walk(RA, 20'h12345, 1, 1'b0, 1'b0, "valid fill");
    run_walk(RA, 20'h00400, 1, 1'b0, 1'b0, "null pointer");
    run_walk(RA, 20'h00800, 2, 1'b0, 1'b0, "top flag clear");
    run_walk(RA, 20'h00C07, 1, 1'b0, 1'b0, "leaf flag clear");
    run_walk(RB, 20'hFFFFF, 3, 1'b1, 1'b0, "max index throttled");
    run_walk(RA, 20'h00000, 1, 1'b1, 1'b0, "zero index");
    run_walk(RA, 20'h12345, 2, 1'b0, 1'b1, "request while busy");

    repeat (3) @(negedge clk);
    #1.5;
    chk(!busy, "R2 no late start", {31'h0, busy}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule